// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a two-wire bus target that gives an external bus controller read and write access to a register space of up to 256 bytes. It runs entirely on the system clock. Both bus lines are oversampled, and START and STOP conditions are found from their synchronised edges. SDA is driven through an open-drain enable: the output pulls the line low when set and releases it otherwise. Only a single fixed 7-bit device address is answered.

The register space itself sits outside the block. The block presents a word address, write data and a one-cycle write strobe, and it takes back combinational read data for the addressed location.

A word pointer persists across transfers. It is loaded by the word-address byte of a write. It advances by one after every data byte received or sent, and wraps at the top of the space. The same pointer serves random writes, sequential writes, current-address reads, random reads (a dummy write of the word address followed by a repeated START) and sequential reads.

Top module: `i2c_regport`

## Requirements
- R1: After reset `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: A START (SDA falling while SCL is high) restarts address reception at any point, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the block to idle.
- R3: The block pulls SDA low in the acknowledge slot only when the first byte after a START carries device address 7'b0111010 in bits 7..1. Bit 0 is R/W, with 1 meaning read, so the write byte is 0x74 and the read byte is 0x75. On any other address it never drives SDA and never strobes `reg_we` until the next START or STOP.
- R4: A random write is START, 0x74, word address, one data byte, STOP. Each of the three bytes is acknowledged. `reg_we` pulses for exactly one cycle, with `reg_addr` equal to the word address and `reg_wdata` equal to the data byte.
- R5: In a sequential write, each further data byte goes to the next location, and the location after 255 is 0.
- R6: A current-address read (START, 0x75) returns the byte at the pointer left by the previous transfer, which is one past the last location written or read.
- R7: A random read (START, 0x74, word address, repeated START, 0x75) returns the byte at that word address.
- R8: Read data is sent MSB first. Each byte acknowledged by the controller is followed by the byte at the next location, and the location after 255 is 0.
- R9: A NACK from the controller after a read byte ends the transfer. The block releases SDA and drives it no more until a new START.
- R10: The block changes its SDA drive only while SCL is low, so every read bit is steady for the whole SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_addr | output | ADDR_W | Word pointer, the register location addressed |
| reg_wdata | output | 8 | Byte to store when `reg_we` is high |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Content of the location at `reg_addr` |

## Verification
Directed transfers cover each of the five operation forms once at fixed locations. Comparing current-address reads against random reads separates a pointer that persists from one that is reloaded. Sequential transfers that start at 254 and 255 expose a pointer that fails to wrap or that steps at the wrong moment. A transfer to a neighbouring device address, and a START that cuts a byte short, check the ignore and resynchronise paths. Seeded random mixes of all five forms over random locations then check that the pointer and the register contents stay consistent with an independent model over long sequences.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WADDR,
      ST_WADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK
   } tgt_state_t;

   typedef struct packed {
      logic scl;
      logic scl_rise;
      logic scl_fall;
      logic sda;
      logic start;
      logic stop;
   } bus_evt_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
   import i2c_regport_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t ev
);

   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   always_comb begin
      ev.scl      = scl_s;
      ev.sda      = sda_s;
      ev.scl_rise = scl_s & ~scl_p;
      ev.scl_fall = ~scl_s & scl_p;
      ev.start    = scl_s & scl_p & sda_p & ~sda_s;
      ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
   end

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
   import i2c_regport_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b0111010,
   parameter int         ADDR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          ev,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              oe,
   output logic [ADDR_W-1:0] ptr,
   output logic [BYTE_W-1:0] wdata,
   output logic              we
);

   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr_w
      $error("i2c_target_ctrl: ADDR_W must lie in 1..8");
   end

   localparam logic [3:0]        BITS_LAST = 4'(BYTE_W);
   localparam logic [ADDR_W-1:0] PTR_ONE   = ADDR_W'(1);

   tgt_state_t        state;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] sh;
   logic              rd_mode;
   logic              mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         sh      <= '0;
         ptr     <= '0;
         oe      <= 1'b0;
         we      <= 1'b0;
         wdata   <= '0;
         rd_mode <= 1'b0;
         mack    <= 1'b0;
      end else begin
         we <= 1'b0;
         if (we) ptr <= ptr + PTR_ONE;
         if (ev.start) begin
            state <= ST_DEV;
            cnt   <= '0;
            oe    <= 1'b0;
         end else if (ev.stop) begin
            state <= ST_IDLE;
            cnt   <= '0;
            oe    <= 1'b0;
         end else begin
            case (state)
               ST_DEV, ST_WADDR, ST_WDATA: begin
                  if (ev.scl_rise && cnt != BITS_LAST) begin
                     sh  <= {sh[BYTE_W-2:0], ev.sda};
                     cnt <= cnt + 4'd1;
                  end else if (ev.scl_fall && cnt == BITS_LAST) begin
                     cnt <= '0;
                     if (state == ST_DEV) begin
                        if (sh[7:1] == DEV_ADDR) begin
                           oe      <= 1'b1;
                           rd_mode <= sh[0];
                           state   <= ST_DEV_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_WADDR) begin
                        ptr   <= sh[ADDR_W-1:0];
                        oe    <= 1'b1;
                        state <= ST_WADDR_ACK;
                     end else begin
                        wdata <= sh;
                        we    <= 1'b1;
                        oe    <= 1'b1;
                        state <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (ev.scl_fall) begin
                     cnt <= '0;
                     if (rd_mode) begin
                        sh    <= rd_data;
                        oe    <= ~rd_data[BYTE_W-1];
                        state <= ST_RDATA;
                     end else begin
                        oe    <= 1'b0;
                        state <= ST_WADDR;
                     end
                  end
               end
               ST_WADDR_ACK, ST_WDATA_ACK: begin
                  if (ev.scl_fall) begin
                     cnt   <= '0;
                     oe    <= 1'b0;
                     state <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (ev.scl_fall) begin
                     if (cnt != 4'(BYTE_W - 1)) begin
                        sh  <= {sh[BYTE_W-2:0], 1'b0};
                        oe  <= ~sh[BYTE_W-2];
                        cnt <= cnt + 4'd1;
                     end else begin
                        oe    <= 1'b0;
                        ptr   <= ptr + PTR_ONE;
                        cnt   <= '0;
                        state <= ST_RACK;
                     end
                  end
               end
               ST_RACK: begin
                  if (ev.scl_rise) begin
                     mack <= ~ev.sda;
                  end else if (ev.scl_fall) begin
                     if (mack) begin
                        sh    <= rd_data;
                        oe    <= ~rd_data[BYTE_W-1];
                        state <= ST_RDATA;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  cnt <= '0;
               end
            endcase
         end
      end
   end

   // R10: drive level never moves while the synchronised clock stays high
   a_r10_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.scl && $past(ev.scl)) |-> $stable(oe));

   // R4: the write strobe lasts one cycle
   a_r4_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !we);

   // R5: each stored byte moves the pointer to the next location
   a_r5_ptr_steps_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ptr == $past(ptr) + PTR_ONE));

   // R3: the address acknowledge only follows a matching device address
   a_r3_ack_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV_ACK) |-> (sh[7:1] == DEV_ADDR));

   // R9: once idle the line is released
   a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !oe);

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
   import i2c_regport_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b0111010,
   parameter int         ADDR_W      = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   output logic              reg_we,
   input  logic [7:0]        reg_rdata
);

   localparam int N_LINES = 2;

   logic [N_LINES-1:0] line_raw;
   logic [N_LINES-1:0] line_sync;
   bus_evt_t           ev;

   assign line_raw = {sda_i, scl_i};

   for (genvar g = 0; g < N_LINES; g++) begin : g_sync
      i2c_line_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (1'b1)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (line_raw[g]),
         .q     (line_sync[g])
      );
   end

   i2c_bus_events u_events (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (line_sync[0]),
      .sda_s (line_sync[1]),
      .ev    (ev)
   );

   i2c_target_ctrl #(
      .DEV_ADDR (DEV_ADDR),
      .ADDR_W   (ADDR_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev),
      .rd_data (reg_rdata),
      .oe      (sda_oe),
      .ptr     (reg_addr),
      .wdata   (reg_wdata),
      .we      (reg_we)
   );

endmodule

// File: tb/i2c_regport_bench.sv
module i2c_regport_bench;

   localparam int Q = 8;
   localparam logic [7:0] WR_BYTE = 8'h74;
   localparam logic [7:0] RD_BYTE = 8'h75;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_line;
   logic       sda_oe;
   logic [7:0] reg_addr;
   logic [7:0] reg_wdata;
   logic       reg_we;
   logic [7:0] reg_rdata;

   logic [7:0] mem     [256];
   logic [7:0] exp_mem [256];
   logic [7:0] exp_ptr;
   int         we_cnt = 0;
   int         n_chk = 0;
   int         n_bad = 0;

   always #10 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   i2c_regport u_i2c_regport (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata)
   );

   function automatic logic [7:0] init_val(input int i);
      return 8'((i * 7 + 3) ^ 8'h5A);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      end else if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
         we_cnt        <= we_cnt + 1;
      end
   end

   assign reg_rdata = mem[reg_addr];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wait_clk(Q);
      m_scl = 1'b1; wait_clk(Q);
      m_sda = 1'b0; wait_clk(Q);
      m_scl = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wait_clk(Q);
      m_scl = 1'b1; wait_clk(Q);
      m_sda = 1'b1; wait_clk(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; wait_clk(Q);
         m_scl = 1'b1; wait_clk(Q);
         m_scl = 1'b0;
      end
      wait_clk(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      send_bits(b, 8);
      m_sda = 1'b1;
      m_scl = 1'b1; wait_clk(Q / 2);
      acked = ~sda_line;
      wait_clk(Q / 2);
      m_scl = 1'b0; wait_clk(Q);
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      bit steady;
      steady = 1'b1;
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         logic s1;
         wait_clk(Q);
         m_scl = 1'b1; wait_clk(Q / 4);
         s1 = sda_line;
         wait_clk(Q / 2);
         if (sda_line !== s1) steady = 1'b0;
         b[i] = s1;
         wait_clk(Q - Q / 4 - Q / 2);
         m_scl = 1'b0;
      end
      chk(steady, "R10 read bit steady while SCL high", int'(steady), 1);
      wait_clk(2);
      m_sda = give_ack ? 1'b0 : 1'b1;
      wait_clk(Q);
      m_scl = 1'b1; wait_clk(Q);
      m_scl = 1'b0; wait_clk(2);
      m_sda = 1'b1;
      wait_clk(Q - 2);
   endtask

   task automatic wr_txn(input logic [7:0] a, input int n, input string tag);
      bit ack;
      int we0;
      logic [7:0] d;
      bus_start();
      send_byte(WR_BYTE, ack); chk(ack, "R3 device address ack", int'(ack), 1);
      send_byte(a, ack);       chk(ack, "R4 word address ack", int'(ack), 1);
      for (int i = 0; i < n; i++) begin
         logic [7:0] loc;
         loc = a + 8'(i);
         d = 8'($urandom);
         we0 = we_cnt;
         send_byte(d, ack);
         chk(ack, "R4 data ack", int'(ack), 1);
         exp_mem[loc] = d;
         chk(mem[loc] == d, tag, int'(mem[loc]), int'(d));
         chk(we_cnt == we0 + 1, "R4 one strobe per byte", we_cnt - we0, 1);
      end
      exp_ptr = a + 8'(n);
      bus_stop();
   endtask

   task automatic rd_txn(input bit set_addr, input logic [7:0] a, input int n, input string tag);
      bit ack;
      logic [7:0] d;
      bus_start();
      if (set_addr) begin
         send_byte(WR_BYTE, ack); chk(ack, "R7 dummy write ack", int'(ack), 1);
         send_byte(a, ack);       chk(ack, "R7 word address ack", int'(ack), 1);
         exp_ptr = a;
         bus_start();
      end
      send_byte(RD_BYTE, ack); chk(ack, "R3 read address ack", int'(ack), 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, d);
         chk(d == exp_mem[exp_ptr], tag, int'(d), int'(exp_mem[exp_ptr]));
         exp_ptr = exp_ptr + 8'd1;
      end
      wait_clk(Q);
      chk(sda_oe == 1'b0, "R9 released after NACK", int'(sda_oe), 0);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      bit ack;
      int we0;
      void'($urandom(32'h1C2B_5EED));
      for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
      exp_ptr = 8'h00;
      wait_clk(6);
      // R1: reset state
      chk(sda_oe == 1'b0, "R1 sda_oe in reset", int'(sda_oe), 0);
      chk(reg_we == 1'b0, "R1 reg_we in reset", int'(reg_we), 0);
      chk(reg_addr == 8'h00, "R1 reg_addr in reset", int'(reg_addr), 0);
      rst_n = 1'b1;
      wait_clk(4);
      chk(sda_oe == 1'b0 && reg_addr == 8'h00, "R1 after reset release", int'(sda_oe), 0);

      wr_txn(8'h10, 1, "R4 random write stored");
      rd_txn(1'b0, 8'h00, 1, "R6 current-address read");
      rd_txn(1'b1, 8'h10, 1, "R7 random read");
      wr_txn(8'hFE, 3, "R5 sequential write with wrap");
      rd_txn(1'b1, 8'hFE, 4, "R8 sequential read with wrap");
      // R9: after the NACKed read the next current read continues at the pointer
      rd_txn(1'b0, 8'h00, 2, "R9 R6 read continues after NACK");

      // R3: foreign device address is ignored until STOP
      we0 = we_cnt;
      bus_start();
      send_byte(8'h76, ack); chk(!ack, "R3 foreign address no ack", int'(ack), 0);
      send_byte(8'h20, ack); chk(!ack, "R3 ignored byte no ack", int'(ack), 0);
      send_byte(8'hC3, ack); chk(!ack, "R3 ignored data no ack", int'(ack), 0);
      bus_stop();
      chk(we_cnt == we0, "R3 no strobe for foreign address", we_cnt - we0, 0);
      chk(mem[8'h20] == exp_mem[8'h20], "R3 location untouched", int'(mem[8'h20]), int'(exp_mem[8'h20]));

      // R2: START in the middle of a byte resynchronises
      bus_start();
      send_bits(WR_BYTE, 3);
      wr_txn(8'h42, 1, "R2 write after aborted byte");
      rd_txn(1'b1, 8'h42, 1, "R2 read back after abort");

      for (int t = 0; t < 30; t++) begin
         int kind;
         int n;
         logic [7:0] a;
         kind = $urandom_range(0, 4);
         n = $urandom_range(1, 4);
         a = 8'($urandom);
         case (kind)
            0: wr_txn(a, 1, "R4 random write");
            1: wr_txn(a, n, "R5 random sequential write");
            2: rd_txn(1'b0, a, n, "R6 random current read");
            3: rd_txn(1'b1, a, 1, "R7 random read");
            default: rd_txn(1'b1, a, n, "R8 random sequential read");
         endcase
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule